// File: doc/BRIEF.md
# Processor Interrupt Recognition Sequencer

This block sits on the processor side of an interrupt path. It watches a 3-bit encoded request level from an external interrupt controller and decides, at each instruction boundary, whether to take an interrupt. Levels 1 to 6 are compared with the 3-bit mask held in the status register. Level 7 cannot be masked and counts only when the request moves into level 7.

Once an interrupt is accepted, the block updates the status register and then runs the exception entry on a simple request/ready bus. It first reads a byte-wide vector in an acknowledge cycle. It then writes the two longwords of the stack frame below the supervisor stack pointer. Last, it reads the handler address from the vector table and hands that address back to the core with a one-cycle strobe.

The core stalls while `seqBusy` is high. Instruction completion and status-register writes from the core are ignored during that time.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the status register reads 0x2700 (bit 13 supervisor set, bit 15 trace clear, mask bits 10:8 = 7), and `seqBusy` and `busReq` are low.
- R2: A request level of 1 to 6 is accepted only in a cycle with `instrDone` high, and only when the level is strictly greater than the mask in status bits 10:8. A level equal to or below the mask, or a level with no boundary strobe, starts nothing.
- R3: Level 7 is accepted at a boundary whatever the mask, provided the request moved into level 7 at that cycle or since the last level-7 acceptance. Holding level 7 does not cause a second acceptance.
- R4: On acceptance the status register gets bit 13 set, bit 15 cleared and bits 10:8 set to the accepted level, visible on `srOut` in the next cycle.
- R5: The first bus step is the acknowledge read. During it `busType` = 2'b11, `busByte` = 1, `busWrite` = 0 and `busAddr` equals the accepted level, zero-extended. Every other step drives `busType` = 2'b00 and `busByte` = 0.
- R6: The second step writes the word {vector[7:0] in bits 31:24, zeros in bits 23:16, the status register value before acceptance in bits 15:0} to address `sspIn` − 8. `sspIn` is sampled at acceptance.
- R7: The third step writes the `curPc` value sampled at acceptance to address `sspIn` − 4.
- R8: The fourth step reads address `vbrIn` + 4 × vector. The read data appears on `handlerPc`, with `handlerValid` high for exactly one cycle, in the cycle after the ready. `seqBusy` drops in that same cycle.
- R9: An acknowledged vector below 64 is replaced by vector 24 for both the frame word and the table address.
- R10: A status-register load from the core in the same cycle as `instrDone` takes effect first. The loaded mask governs the decision, and the loaded value is the one pushed in the frame.
- R11: Each bus step holds its request, address and data until `busReady` is seen high. `instrDone` and level changes during a sequence do not alter the sequence in progress.
- R12: A transition into level 7 during a sequence is remembered. It is taken at the next boundary even if the request has since fallen to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqLevel | input | 3 | Encoded interrupt request level, 0 = none |
| instrDone | input | 1 | Instruction boundary strobe |
| curPc | input | 32 | Program counter of the instruction at the boundary |
| srLoadEn | input | 1 | Core writes the status register this cycle |
| srLoadData | input | 16 | Value written by the core |
| sspIn | input | 32 | Supervisor stack pointer |
| vbrIn | input | 32 | Vector table base address |
| busReq | output | 1 | Bus step active |
| busWrite | output | 1 | 1 = write step |
| busByte | output | 1 | 1 = byte-wide transfer, 0 = longword |
| busType | output | 2 | Transfer type, 2'b11 = acknowledge, 2'b00 = normal |
| busAddr | output | 32 | Bus address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, vector in bits 7:0 during acknowledge |
| busReady | input | 1 | Completes the current bus step |
| srOut | output | 16 | Current status register |
| seqBusy | output | 1 | Exception entry in progress |
| handlerValid | output | 1 | One-cycle strobe with the handler address |
| handlerPc | output | 32 | Handler address read from the vector table |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a status-register load by the core and the boundary decision. The bench raises `srLoadEn` and `instrDone` together, once with a mask that admits the pending level and once with a mask that blocks it. It then judges the outcome from whether `busReq` rises and from the old-SR field of the pushed frame word.

The second pair is a transition into level 7 and a boundary strobe. The bench makes this happen once at the same edge, and once while a lower-level sequence is stalled on the acknowledge step. It expects a single level-7 entry at the next boundary, and no second entry while the level stays at 7.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IACK,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_FETCH
  } seqState_t;

  typedef enum logic [1:0] {
    ADDR_ACK,
    ADDR_FRAME_SR,
    ADDR_FRAME_PC,
    ADDR_TABLE
  } addrSel_t;

  typedef struct packed {
    logic     accept;
    logic     capVector;
    logic     capHandler;
    logic     busReq;
    logic     busWrite;
    logic     busByte;
    logic     ackCycle;
    addrSel_t addrSel;
  } seqCtl_t;

  localparam logic [1:0] TT_NORMAL = 2'b00;
  localparam logic [1:0] TT_ACK    = 2'b11;

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    instrDone,
  input  logic    takeReq,
  input  logic    busReady,
  output seqCtl_t ctl,
  output logic    busy
);

  seqState_t stateQ, stateD;

  always_comb begin
    ctl = '0;
    ctl.addrSel = ADDR_ACK;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (instrDone && takeReq) begin
          ctl.accept = 1'b1;
          stateD = ST_IACK;
        end
      end
      ST_IACK: begin
        ctl.busReq = 1'b1;
        ctl.busByte = 1'b1;
        ctl.ackCycle = 1'b1;
        ctl.addrSel = ADDR_ACK;
        ctl.capVector = busReady;
        if (busReady) stateD = ST_PUSH_SR;
      end
      ST_PUSH_SR: begin
        ctl.busReq = 1'b1;
        ctl.busWrite = 1'b1;
        ctl.addrSel = ADDR_FRAME_SR;
        if (busReady) stateD = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        ctl.busReq = 1'b1;
        ctl.busWrite = 1'b1;
        ctl.addrSel = ADDR_FRAME_PC;
        if (busReady) stateD = ST_FETCH;
      end
      ST_FETCH: begin
        ctl.busReq = 1'b1;
        ctl.addrSel = ADDR_TABLE;
        ctl.capHandler = busReady;
        if (busReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

  // R2
  accept_enters_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |=> (stateQ == ST_IACK));

  // R11
  ack_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IACK && !busReady) |=> (stateQ == ST_IACK));

  // R11
  fetch_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FETCH && !busReady) |=> (stateQ == ST_FETCH));

endmodule

// File: rtl/irq_seq_datapath.sv
module irq_seq_datapath
  import irq_seq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SR_W      = 16,
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int MASK_LSB  = 8,
  parameter int S_BIT     = 13,
  parameter int T_BIT     = 15,
  parameter int FIRST_USER_VEC = 64,
  parameter int SPUR_VEC  = 24,
  parameter logic [SR_W-1:0] SR_RESET = 16'h2700
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              busy,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic [DATA_W-1:0] curPc,
  input  logic              srLoadEn,
  input  logic [SR_W-1:0]   srLoadData,
  input  logic [DATA_W-1:0] sspIn,
  input  logic [DATA_W-1:0] vbrIn,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              takeReq,
  output logic [DATA_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [SR_W-1:0]   srOut,
  output logic              handlerValid,
  output logic [DATA_W-1:0] handlerPc
);

  localparam int FRAME_PAD = DATA_W - VEC_W - SR_W;
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};
  localparam logic [VEC_W-1:0] USER_LO = VEC_W'(FIRST_USER_VEC);
  localparam logic [VEC_W-1:0] SPUR    = VEC_W'(SPUR_VEC);
  localparam logic [DATA_W-1:0] SR_WORD_OFS = DATA_W'(8);
  localparam logic [DATA_W-1:0] PC_WORD_OFS = DATA_W'(4);

  logic [SR_W-1:0]   srQ, savedSrQ, effSr;
  logic              top7Q, nmiPendQ;
  logic [LVL_W-1:0]  lvlQ, takeLvl;
  logic [DATA_W-1:0] pcQ, sspQ, handlerQ;
  logic [VEC_W-1:0]  vecQ, vecIn;
  logic              hvQ;
  logic              topEdge, nmiNow, maskedOk;

  // the core's write lands before the boundary decision
  assign effSr    = (srLoadEn && !busy) ? srLoadData : srQ;
  assign topEdge  = (irqLevel == LVL_TOP) && !top7Q;
  assign nmiNow   = nmiPendQ || topEdge;
  assign maskedOk = (irqLevel != LVL_TOP) &&
                    (irqLevel > effSr[MASK_LSB +: LVL_W]);
  assign takeReq  = nmiNow || maskedOk;
  assign takeLvl  = nmiNow ? LVL_TOP : irqLevel;

  assign vecIn = (busRdata[VEC_W-1:0] < USER_LO) ? SPUR : busRdata[VEC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      top7Q    <= 1'b0;
      nmiPendQ <= 1'b0;
    end else begin
      top7Q    <= (irqLevel == LVL_TOP);
      nmiPendQ <= (nmiPendQ || topEdge) && !(ctl.accept && nmiNow);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srQ      <= SR_RESET;
      savedSrQ <= '0;
      lvlQ     <= '0;
      pcQ      <= '0;
      sspQ     <= '0;
    end else if (ctl.accept) begin
      srQ                       <= effSr;
      srQ[S_BIT]                <= 1'b1;
      srQ[T_BIT]                <= 1'b0;
      srQ[MASK_LSB +: LVL_W]    <= takeLvl;
      savedSrQ                  <= effSr;
      lvlQ                      <= takeLvl;
      pcQ                       <= curPc;
      sspQ                      <= sspIn;
    end else if (srLoadEn && !busy) begin
      srQ <= srLoadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ     <= '0;
      handlerQ <= '0;
      hvQ      <= 1'b0;
    end else begin
      if (ctl.capVector) vecQ <= vecIn;
      if (ctl.capHandler) handlerQ <= busRdata;
      hvQ <= ctl.capHandler;
    end
  end

  always_comb begin
    busAddr  = '0;
    busWdata = '0;
    unique case (ctl.addrSel)
      ADDR_ACK:      busAddr = DATA_W'(lvlQ);
      ADDR_FRAME_SR: begin
        busAddr  = sspQ - SR_WORD_OFS;
        busWdata = {vecQ, {FRAME_PAD{1'b0}}, savedSrQ};
      end
      ADDR_FRAME_PC: begin
        busAddr  = sspQ - PC_WORD_OFS;
        busWdata = pcQ;
      end
      ADDR_TABLE:    busAddr = vbrIn + {{(DATA_W-VEC_W-2){1'b0}}, vecQ, 2'b00};
      default:       busAddr = '0;
    endcase
  end

  assign srOut        = srQ;
  assign handlerValid = hvQ;
  assign handlerPc    = handlerQ;

  // R4
  sr_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |=> (srQ[S_BIT] && !srQ[T_BIT]));

  // R4
  mask_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |=> (srQ[MASK_LSB +: LVL_W] == $past(takeLvl)));

  // R8
  handler_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hvQ |=> !hvQ);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busReq && !busReady) |=> $stable(busAddr));

  // R9
  user_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capVector |=> (vecQ >= USER_LO || vecQ == SPUR));

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SR_W   = 16,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              instrDone,
  input  logic [DATA_W-1:0] curPc,
  input  logic              srLoadEn,
  input  logic [SR_W-1:0]   srLoadData,
  input  logic [DATA_W-1:0] sspIn,
  input  logic [DATA_W-1:0] vbrIn,
  output logic              busReq,
  output logic              busWrite,
  output logic              busByte,
  output logic [1:0]        busType,
  output logic [DATA_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic [SR_W-1:0]   srOut,
  output logic              seqBusy,
  output logic              handlerValid,
  output logic [DATA_W-1:0] handlerPc
);

  seqCtl_t ctl;
  logic    takeReq;
  logic    busy;

  irq_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instrDone(instrDone),
    .takeReq  (takeReq),
    .busReady (busReady),
    .ctl      (ctl),
    .busy     (busy)
  );

  irq_seq_datapath #(
    .DATA_W(DATA_W),
    .SR_W  (SR_W),
    .LVL_W (LVL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .busy        (busy),
    .irqLevel    (irqLevel),
    .curPc       (curPc),
    .srLoadEn    (srLoadEn),
    .srLoadData  (srLoadData),
    .sspIn       (sspIn),
    .vbrIn       (vbrIn),
    .busRdata    (busRdata),
    .busReady    (busReady),
    .takeReq     (takeReq),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .srOut       (srOut),
    .handlerValid(handlerValid),
    .handlerPc   (handlerPc)
  );

  assign busReq   = ctl.busReq;
  assign busWrite = ctl.busWrite;
  assign busByte  = ctl.busByte;
  assign busType  = ctl.ackCycle ? TT_ACK : TT_NORMAL;
  assign seqBusy  = busy;

  // R5
  ack_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busType == TT_ACK) |-> (busReq && busByte && !busWrite));

  // R8
  idle_after_handler_chk: assert property (@(posedge clk) disable iff (!rstN)
    handlerValid |-> !seqBusy);

endmodule

// File: tb/irq_seq_top_bench.sv
module irq_seq_top_bench;

  localparam logic [31:0] SSP = 32'h0000_8000;
  localparam logic [31:0] VBR = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  irqLevel = '0;
  logic        instrDone = 1'b0;
  logic [31:0] curPc = '0;
  logic        srLoadEn = 1'b0;
  logic [15:0] srLoadData = '0;
  logic [31:0] sspIn = SSP;
  logic [31:0] vbrIn = VBR;
  logic        busReq, busWrite, busByte;
  logic [1:0]  busType;
  logic [31:0] busAddr, busWdata;
  logic [31:0] busRdata = '0;
  logic        busReady = 1'b0;
  logic [15:0] srOut;
  logic        seqBusy, handlerValid;
  logic [31:0] handlerPc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_seq_top u_irq_seq_top (
    .clk(clk), .rstN(rstN), .irqLevel(irqLevel), .instrDone(instrDone),
    .curPc(curPc), .srLoadEn(srLoadEn), .srLoadData(srLoadData),
    .sspIn(sspIn), .vbrIn(vbrIn), .busReq(busReq), .busWrite(busWrite),
    .busByte(busByte), .busType(busType), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .srOut(srOut), .seqBusy(seqBusy), .handlerValid(handlerValid),
    .handlerPc(handlerPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // boundary strobe with optional same-cycle status load
  task automatic boundary(input logic [2:0] lvl, input logic ld, input logic [15:0] ldv);
    @(negedge clk);
    irqLevel = lvl; instrDone = 1'b1; srLoadEn = ld; srLoadData = ldv;
    @(negedge clk);
    instrDone = 1'b0; srLoadEn = 1'b0;
  endtask

  task automatic loadSr(input logic [15:0] v);
    @(negedge clk);
    srLoadEn = 1'b1; srLoadData = v;
    @(negedge clk);
    srLoadEn = 1'b0;
  endtask

  task automatic step(input string req, input logic wr, input logic [1:0] tt,
                      input logic by, input logic [31:0] addr, input logic chkData,
                      input logic [31:0] wd, input logic [31:0] rd, input int waits);
    chk({req, " req"}, {31'b0, busReq}, 32'd1);
    chk({req, " write"}, {31'b0, busWrite}, {31'b0, wr});
    chk({req, " type"}, {30'b0, busType}, {30'b0, tt});
    chk({req, " byte"}, {31'b0, busByte}, {31'b0, by});
    chk({req, " addr"}, busAddr, addr);
    if (chkData) chk({req, " wdata"}, busWdata, wd);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R11 hold addr", busAddr, addr);
      chk("R11 hold req", {31'b0, busReq}, 32'd1);
    end
    busReady = 1'b1; busRdata = rd;
    @(negedge clk);
    busReady = 1'b0; busRdata = '0;
  endtask

  // full entry following an acceptance that happened at the last edge
  task automatic runEntry(input logic [2:0] lvl, input logic [7:0] vecRet,
                          input logic [7:0] vecExp, input logic [15:0] oldSr,
                          input logic [15:0] newSr, input logic [31:0] pc,
                          input int waits);
    logic [31:0] hnd;
    hnd = 32'hA000_0000 | {24'b0, vecExp};
    chk("R4 sr after accept", {16'b0, srOut}, {16'b0, newSr});
    step("R5 ack", 1'b0, 2'b11, 1'b1, {29'b0, lvl}, 1'b0, '0, {24'hFFFF00, vecRet}, waits);
    step("R6 frame sr", 1'b1, 2'b00, 1'b0, SSP - 8, 1'b1, {vecExp, 8'h00, oldSr}, '0, waits);
    step("R7 frame pc", 1'b1, 2'b00, 1'b0, SSP - 4, 1'b1, pc, '0, 0);
    step("R8 table", 1'b0, 2'b00, 1'b0, VBR + {22'b0, vecExp, 2'b00}, 1'b0, '0, hnd, waits);
    chk("R8 valid", {31'b0, handlerValid}, 32'd1);
    chk("R8 handler", handlerPc, hnd);
    chk("R8 busy low", {31'b0, seqBusy}, 32'd0);
    @(negedge clk);
    chk("R8 single pulse", {31'b0, handlerValid}, 32'd0);
  endtask

  task automatic expectIdle(input string req);
    chk({req, " no busy"}, {31'b0, seqBusy}, 32'd0);
    chk({req, " no req"}, {31'b0, busReq}, 32'd0);
  endtask

  task automatic testReset;
    chk("R1 sr reset", {16'b0, srOut}, 32'h2700);
    expectIdle("R1");
  endtask

  task automatic testMaskBlock;
    loadSr(16'hA300);
    chk("R2 sr loaded", {16'b0, srOut}, 32'hA300);
    boundary(3'd3, 1'b0, '0);
    expectIdle("R2 equal level");
    boundary(3'd1, 1'b0, '0);
    expectIdle("R2 lower level");
    @(negedge clk); irqLevel = 3'd5;
    @(negedge clk); @(negedge clk);
    expectIdle("R2 no boundary");
  endtask

  task automatic testNormal;
    curPc = 32'h0000_1234;
    boundary(3'd5, 1'b0, '0);
    curPc = 32'h0000_9999;
    runEntry(3'd5, 8'h45, 8'h45, 16'hA300, 16'h2500, 32'h0000_1234, 2);
    irqLevel = 3'd0;
  endtask

  task automatic testSpurious;
    curPc = 32'h0000_2000;
    boundary(3'd6, 1'b0, '0);
    runEntry(3'd6, 8'h10, 8'd24, 16'h2500, 16'h2600, 32'h0000_2000, 1); // R9
    irqLevel = 3'd0;
  endtask

  task automatic testNmi;
    loadSr(16'h2700);
    curPc = 32'h0000_3000;
    boundary(3'd7, 1'b0, '0);
    runEntry(3'd7, 8'h50, 8'h50, 16'h2700, 16'h2700, 32'h0000_3000, 0); // R3
    boundary(3'd7, 1'b0, '0);
    expectIdle("R3 held level seven");
    irqLevel = 3'd0;
  endtask

  task automatic testNmiWhileBusy;
    loadSr(16'h2000);
    curPc = 32'h0000_4000;
    boundary(3'd2, 1'b0, '0);
    irqLevel = 3'd7; instrDone = 1'b1;
    @(negedge clk);
    irqLevel = 3'd0; instrDone = 1'b0;
    runEntry(3'd2, 8'h42, 8'h42, 16'h2000, 16'h2200, 32'h0000_4000, 1); // R11
    curPc = 32'h0000_5000;
    boundary(3'd0, 1'b0, '0);
    runEntry(3'd7, 8'h47, 8'h47, 16'h2200, 16'h2700, 32'h0000_5000, 0); // R12
  endtask

  task automatic testSameCycleLoad;
    curPc = 32'h0000_6000;
    boundary(3'd4, 1'b1, 16'h2100);
    runEntry(3'd4, 8'h44, 8'h44, 16'h2100, 16'h2400, 32'h0000_6000, 0); // R10
    loadSr(16'h2000);
    boundary(3'd5, 1'b1, 16'h2600);
    expectIdle("R10 blocking load");
    chk("R10 sr", {16'b0, srOut}, 32'h2600);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMaskBlock();
    testNormal();
    testSpurious();
    testNmi();
    testNmiWhileBusy();
    testSameCycleLoad();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule